// File: doc/BRIEF.md
# Link-Qualifying Pattern Checker

This block sits behind one receive lane of a serial link under test. Each cycle it may be handed one parallel word that has already been deserialized and aligned. It predicts what that word should be for the selected test pattern, compares bit by bit, and keeps a debounced "link good" indication. Two saturating statistics counters run beside it: the number of words received and the number of bit errors seen while the link is qualified. A lane-level test harness uses one instance per lane. It drives the same pattern code as the far-end generator, waits for the link indication, then reads the counters to compute an error ratio.

The local predictor does not need a seed from the transmitter. While the link is not qualified, the checker rebuilds its pattern state from the bits it has just received, so any clean stretch of the pattern locks it. Once the link is qualified, the predictor runs on its own, so isolated bit errors are counted and do not corrupt the reference. A counter-clear strobe zeroes the statistics without touching the link logic.

Top module: `link_pattern_checker`

## Requirements
- R1: Pattern codes on `patSel` are: 0 PRBS with next bit = bit 7 back XOR bit 6 back; 1 PRBS 15/14; 2 PRBS 23/18; 3 PRBS 31/28; 4 alternating clock, where the next bit is the inverse of the previous bit; 5 slow clock of ten ones and ten zeros, where the next bit is the inverse of the bit ten back. Word bit 0 is the earliest bit in time. The predictor's 31-bit history is all zeros after reset.
- R2: While `linkUp` is low, each valid word's received bits are shifted into the history, so the next word is predicted from received data.
- R3: While `linkUp` is high, the predicted bits are shifted into the history instead, so a corrupted word does not disturb the prediction of later words.
- R4: `linkUp` rises at the clock edge that accepts the fifth consecutive valid word with no mismatched bit.
- R5: `linkUp` falls at the edge that accepts the fifth consecutive valid word containing at least one mismatch. A clean word restarts that run, and an errored word restarts the clean run.
- R6: `wordErr` is high in the cycle after a valid word with any mismatch, and low otherwise.
- R7: `wordCount` increases by one per valid word and holds at its all-ones value instead of wrapping.
- R8: `errorCount` adds the number of mismatched bits of each valid word accepted while `linkUp` was high, saturating at all ones. Words accepted while `linkUp` was low add nothing.
- R9: `clrStats` zeroes both counters at the next edge and takes precedence over a word accepted in the same cycle. It does not change `linkUp`.
- R10: Cycles with `inValid` low change neither the prediction, the link runs, `linkUp` nor the counters, whatever `rxWord` holds.
- R11: Pattern codes 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane word clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | `rxWord` carries a word this cycle |
| rxWord | input | WORD_W | Received parallel word, bit 0 earliest |
| patSel | input | 3 | Selected test pattern code |
| clrStats | input | 1 | Zero both statistics counters |
| linkUp | output | 1 | Debounced link-qualified flag |
| wordErr | output | 1 | Previous accepted word had a mismatch |
| wordCount | output | CNT_W | Saturating count of accepted words |
| errorCount | output | CNT_W | Saturating count of bit errors while qualified |

## Verification
Every pattern code, including a reserved one, is run through the same sequence. A clean stream from an arbitrary non-zero start point shows that the predictor seeds itself from received data. Single-bit corruptions while qualified show free-running prediction and popcount accounting. Runs of four and five errored words separate the restart of the bad run from the actual drop, and a clean stream after the drop checks relock. Idle cycles carrying junk data, a clear that coincides with a valid word, and long all-bits-wrong bursts on a narrow counter build check that idle words are ignored, that clear takes precedence, and that both counters saturate.

// File: rtl/lqpc_pkg.sv
package lqpc_pkg;

  localparam int HIST_W = 31;

  localparam logic [2:0] PAT_PRBS7  = 3'd0;
  localparam logic [2:0] PAT_PRBS15 = 3'd1;
  localparam logic [2:0] PAT_PRBS23 = 3'd2;
  localparam logic [2:0] PAT_PRBS31 = 3'd3;
  localparam logic [2:0] PAT_CLK2   = 3'd4;
  localparam logic [2:0] PAT_CLK10  = 3'd5;

  // datapath -> control: result of one accepted word
  typedef struct packed {
    logic wordGood;
    logic wordBad;
  } cmpStrobe_t;

  // control -> datapath: mode of the predictor and statistics
  typedef struct packed {
    logic freeRun;
    logic countErr;
  } ctrlStrobe_t;

  // hist[0] is the most recent bit, hist[k] the bit k+1 positions back
  function automatic logic nextBit(logic [HIST_W-1:0] hist, logic [2:0] sel);
    logic b;
    case (sel)
      PAT_PRBS15: b = hist[14] ^ hist[13];
      PAT_PRBS23: b = hist[22] ^ hist[17];
      PAT_PRBS31: b = hist[30] ^ hist[27];
      PAT_CLK2:   b = ~hist[0];
      PAT_CLK10:  b = ~hist[9];
      default:    b = hist[6] ^ hist[5];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lqpc_patgen.sv
module lqpc_patgen import lqpc_pkg::*; #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              freeRun,
  input  logic [2:0]        sel,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] expWord
);

  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] histNext;
  logic [WORD_W-1:0] srcWord;

  // predict a whole word, oldest bit first
  always_comb begin
    logic [HIST_W-1:0] h;
    h = hist;
    expWord = '0;
    for (int i = 0; i < WORD_W; i++) begin
      expWord[i] = nextBit(h, sel);
      h = {h[HIST_W-2:0], expWord[i]};
    end
  end

  // reseed from the line while unlocked, free-run once locked
  assign srcWord = freeRun ? expWord : rxWord;

  always_comb begin
    histNext = hist;
    for (int i = 0; i < WORD_W; i++) begin
      histNext = {histNext[HIST_W-2:0], srcWord[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (adv) begin
      hist <= histNext;
    end
  end

  assert_hist_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(hist));

endmodule

// File: rtl/lqpc_satacc.sv
module lqpc_satacc #(
  parameter int CNT_W = 48,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] acc
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0] sum;

  assign sum = {1'b0, acc} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
    end else if (en) begin
      acc <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end
  end

  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (acc == CNT_MAX) && !clr |=> acc == CNT_MAX);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> acc == '0);

endmodule

// File: rtl/lqpc_datapath.sv
module lqpc_datapath import lqpc_pkg::*; #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [2:0]        patSel,
  input  logic              clrStats,
  input  ctrlStrobe_t       ctl,
  output cmpStrobe_t        cmp,
  output logic              wordErr,
  output logic [CNT_W-1:0]  wordCount,
  output logic [CNT_W-1:0]  errorCount
);

  localparam int POP_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] expWord;
  logic [WORD_W-1:0] mism;
  logic [POP_W-1:0]  bitErrs;

  lqpc_patgen #(.WORD_W(WORD_W)) u_gen (
    .clk     (clk),
    .rst     (rst),
    .adv     (inValid),
    .freeRun (ctl.freeRun),
    .sel     (patSel),
    .rxWord  (rxWord),
    .expWord (expWord)
  );

  assign mism = rxWord ^ expWord;

  always_comb begin
    bitErrs = '0;
    for (int i = 0; i < WORD_W; i++) begin
      bitErrs = bitErrs + POP_W'(mism[i]);
    end
  end

  assign cmp.wordGood = inValid && (mism == '0);
  assign cmp.wordBad  = inValid && (mism != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wordErr <= 1'b0;
    end else begin
      wordErr <= cmp.wordBad;
    end
  end

  lqpc_satacc #(.CNT_W(CNT_W), .INC_W(1)) u_wordAcc (
    .clk (clk),
    .rst (rst),
    .clr (clrStats),
    .en  (inValid),
    .inc (1'b1),
    .acc (wordCount)
  );

  lqpc_satacc #(.CNT_W(CNT_W), .INC_W(POP_W)) u_errAcc (
    .clk (clk),
    .rst (rst),
    .clr (clrStats),
    .en  (inValid && ctl.countErr),
    .inc (bitErrs),
    .acc (errorCount)
  );

  assert_flag_src_R6: assert property (@(posedge clk) disable iff (rst)
    wordErr |-> $past(inValid));

  assert_idle_stats_R10: assert property (@(posedge clk) disable iff (rst)
    !inValid && !clrStats |=> $stable(wordCount) && $stable(errorCount));

  assert_err_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !ctl.countErr && !clrStats |=> $stable(errorCount));

  assert_word_step_R7: assert property (@(posedge clk) disable iff (rst)
    inValid && !clrStats |=> wordCount != '0);

endmodule

// File: rtl/lqpc_ctrl.sv
module lqpc_ctrl import lqpc_pkg::*; #(
  parameter int LINK_RUN = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  cmpStrobe_t  cmp,
  output logic        linkUp,
  output ctrlStrobe_t ctl
);

  localparam int RUN_W = $clog2(LINK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LINK_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LINK_RUN - 1);

  logic [RUN_W-1:0] goodRun;
  logic [RUN_W-1:0] badRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      goodRun <= '0;
      badRun  <= '0;
      linkUp  <= 1'b0;
    end else if (cmp.wordGood) begin
      badRun <= '0;
      if (goodRun != RUN_MAX) goodRun <= goodRun + 1'b1;
      if (goodRun >= RUN_LAST) linkUp <= 1'b1;
    end else if (cmp.wordBad) begin
      goodRun <= '0;
      if (badRun != RUN_MAX) badRun <= badRun + 1'b1;
      if (badRun >= RUN_LAST) linkUp <= 1'b0;
    end
  end

  assign ctl.freeRun  = linkUp;
  assign ctl.countErr = linkUp;

  assert_rise_clean_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(linkUp) |-> $past(cmp.wordGood));

  assert_fall_errored_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(linkUp) |-> $past(cmp.wordBad));

  assert_idle_link_R10: assert property (@(posedge clk) disable iff (rst)
    !cmp.wordGood && !cmp.wordBad |=> $stable(linkUp));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $countones({cmp.wordGood, cmp.wordBad}) <= 1);

endmodule

// File: rtl/link_pattern_checker.sv
module link_pattern_checker import lqpc_pkg::*; #(
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 48,
  parameter int LINK_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [2:0]        patSel,
  input  logic              clrStats,
  output logic              linkUp,
  output logic              wordErr,
  output logic [CNT_W-1:0]  wordCount,
  output logic [CNT_W-1:0]  errorCount
);

  ctrlStrobe_t ctl;
  cmpStrobe_t  cmp;

  lqpc_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .rxWord     (rxWord),
    .patSel     (patSel),
    .clrStats   (clrStats),
    .ctl        (ctl),
    .cmp        (cmp),
    .wordErr    (wordErr),
    .wordCount  (wordCount),
    .errorCount (errorCount)
  );

  lqpc_ctrl #(.LINK_RUN(LINK_RUN)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .cmp    (cmp),
    .linkUp (linkUp),
    .ctl    (ctl)
  );

endmodule

// File: tb/link_pattern_checker_tb.sv
module link_pattern_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 16;
  localparam int CW    = 8;
  localparam int RUN   = 5;
  localparam int SATV  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [W-1:0]  rxWord = '0;
  logic [2:0]    patSel = 3'd0;
  logic          clrStats = 1'b0;
  logic          linkUp;
  logic          wordErr;
  logic [CW-1:0] wordCount;
  logic [CW-1:0] errorCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit refHist[$];
  bit txHist[$];
  int mGood, mBad, mWc, mEc;
  bit mLink, mFlag;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_pattern_checker #(.WORD_W(W), .CNT_W(CW), .LINK_RUN(RUN)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .rxWord(rxWord), .patSel(patSel),
    .clrStats(clrStats), .linkUp(linkUp), .wordErr(wordErr),
    .wordCount(wordCount), .errorCount(errorCount)
  );

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // pattern rule from the requirement, applied to a time-ordered bit list
  function automatic bit ruleBit(bit q[$], int code);
    int n = q.size();
    case (code)
      1: return q[n-15] ^ q[n-14];
      2: return q[n-23] ^ q[n-18];
      3: return q[n-31] ^ q[n-28];
      4: return ~q[n-1];
      5: return ~q[n-10];
      default: return q[n-7] ^ q[n-6];
    endcase
  endfunction

  function automatic logic [W-1:0] genTx(int code);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) begin
      w[i] = ruleBit(txHist, code);
      txHist.push_back(w[i]);
      if (txHist.size() > 64) void'(txHist.pop_front());
    end
    return w;
  endfunction

  function automatic logic [W-1:0] predict(int code);
    bit t[$];
    logic [W-1:0] w;
    t = refHist;
    for (int i = 0; i < W; i++) begin
      w[i] = ruleBit(t, code);
      t.push_back(w[i]);
    end
    return w;
  endfunction

  function automatic int sat(int v);
    return (v > SATV) ? SATV : v;
  endfunction

  task automatic doReset(int code);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; clrStats = 1'b0; patSel = 3'(code);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    refHist.delete();
    txHist.delete();
    for (int i = 0; i < 31; i++) begin
      refHist.push_back(1'b0);
      txHist.push_back(1'b1);
    end
    mGood = 0; mBad = 0; mWc = 0; mEc = 0; mLink = 0; mFlag = 0;
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(bit v, logic [W-1:0] d, bit c, int code, string tag);
    logic [W-1:0] e, src;
    int pc;
    bit preLink;
    inValid = v; rxWord = d; clrStats = c;
    @(posedge clk);
    preLink = mLink;
    e = predict(code);
    pc = $countones(d ^ e);
    mFlag = v && (pc != 0);
    if (c) begin
      mWc = 0; mEc = 0;
    end else if (v) begin
      mWc = sat(mWc + 1);
      if (preLink) mEc = sat(mEc + pc);
    end
    if (v) begin
      if (pc == 0) begin
        mBad = 0;
        if (mGood < RUN) mGood++;
        if (mGood == RUN) mLink = 1;
      end else begin
        mGood = 0;
        if (mBad < RUN) mBad++;
        if (mBad == RUN) mLink = 0;
      end
      src = preLink ? e : d;
      for (int i = 0; i < W; i++) begin
        refHist.push_back(src[i]);
        if (refHist.size() > 64) void'(refHist.pop_front());
      end
    end
    @(negedge clk);
    check({tag, " R4 R5 linkUp"}, linkUp, mLink);
    check({tag, " R6 wordErr"}, wordErr, mFlag);
    check({tag, " R7 wordCount"}, wordCount, mWc);
    check({tag, " R8 errorCount"}, errorCount, mEc);
    inValid = 1'b0; clrStats = 1'b0;
  endtask

  task automatic runPattern(int code);
    logic [W-1:0] d;
    doReset(code);
    check("R1 reset linkUp", linkUp, 0);
    check("R1 reset wordErr", wordErr, 0);
    check("R7 reset wordCount", wordCount, 0);
    check("R8 reset errorCount", errorCount, 0);
    // R2: lock from an arbitrary non-zero start
    for (int k = 0; k < 8; k++) step(1, genTx(code), 0, code, "R1 R2 lock");
    check("R4 locked after clean stream", linkUp, 1);
    // R3: single-bit corruptions while locked
    for (int k = 0; k < 2; k++) begin
      d = genTx(code) ^ (16'h1 << (3 * k + code));
      step(1, d, 0, code, "R3 inject");
    end
    for (int k = 0; k < 2; k++) step(1, genTx(code), 0, code, "R3 after inject");
    // R10: junk on idle cycles
    for (int k = 0; k < 3; k++) step(0, 16'hA5C3 ^ 16'(k * 977), 0, code, "R10 idle");
    for (int k = 0; k < 2; k++) step(1, genTx(code), 0, code, "R10 resume");
    // R5: four bad, one good restarts, then five bad drops
    for (int k = 0; k < 4; k++) step(1, genTx(code) ^ 16'h0109, 0, code, "R5 short burst");
    step(1, genTx(code), 0, code, "R5 restart");
    check("R5 still locked", linkUp, 1);
    for (int k = 0; k < 5; k++) step(1, genTx(code) ^ 16'h8001, 0, code, "R5 drop burst");
    check("R5 dropped", linkUp, 0);
    for (int k = 0; k < 8; k++) step(1, genTx(code), 0, code, "R2 relock");
    // R9: clear coincident with a valid errored word, link kept
    step(1, genTx(code) ^ 16'h0010, 1, code, "R9 clear");
    check("R9 cleared words", wordCount, 0);
    step(1, genTx(code), 0, code, "R9 after clear");
  endtask

  initial begin
    for (int code = 0; code < 6; code++) runPattern(code);
    runPattern(6);  // R11 reserved code acts as code 0
    check("R11 reserved code locks", linkUp, 1);
    // saturation on the narrow counter build
    doReset(1);
    for (int k = 0; k < 300; k++) step(1, genTx(1), 0, 1, "R7 fill");
    check("R7 word saturation", wordCount, SATV);
    for (int g = 0; g < 20; g++) begin
      for (int k = 0; k < 4; k++) step(1, ~genTx(1), 0, 1, "R8 heavy");
      step(1, genTx(1), 0, 1, "R8 heavy gap");
    end
    check("R8 error saturation", errorCount, SATV);
    check("R5 burst of four keeps link", linkUp, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule